// File: doc/BRIEF.md
# Parallel CRC-8 Byte Folding Unit

This unit takes an eight-byte message word in a single cycle and turns it into a 16-bit folded value. It does not compute a CRC for each byte and then adjust them. Each byte is carry-less multiplied by a position constant. The constant is x raised to eight times the byte's distance from the end of the word, reduced modulo the generator x^8+x^2+x+1 (0x107). This moves every byte's contribution to the end of the word, so the eight 16-bit products can be combined with one XOR tree. The folded value keeps the full CRC information of the word. A later stage that reduces it modulo the generator gets the CRC-8 of the whole word.

The block has no modulo step. It is meant to sit in front of a reduction stage, or in front of a wider folding stage that collects several words. A word is accepted every cycle. The result is registered and appears one cycle after its valid strobe. Between results the output holds its last value.

Top module: `crcfold_top`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the next cycle shows `outValid` = 0 and `foldOut` = 0.
- R2: `outValid` in a cycle equals `inValid` of the cycle before it, which gives exactly one cycle of latency.
- R3: The byte in `dataIn[8k+7:8k]` is byte k counted from the end of the message, and it is weighted by x^(8k) mod 0x107. For k = 0..7 these weights are 01, 07, 15, 6B, 16, 62, 29, DF. The first message byte sits in `dataIn[63:56]` and takes DF. A word whose only nonzero byte is the last one gives `foldOut` equal to that byte.
- R4: `foldOut` is the XOR of the eight 16-bit carry-less products. For the word 0x3132333435363738 it is 0x1137.
- R5: Reducing `foldOut`·x^8 modulo 0x107 gives the bit-serial CRC-8 of the eight bytes, taken most significant bit first with a zero start value and no final XOR. For the word in R4 this CRC is 0xC7.
- R6: While `inValid` is low, `dataIn` is ignored and `foldOut` keeps its previous value.
- R7: Words presented on consecutive cycles each give their own result on consecutive cycles, in order, with none dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | `dataIn` holds a word to fold |
| dataIn | input | 64 | Message word, first byte in the top byte |
| outValid | output | 1 | `foldOut` holds a new result |
| foldOut | output | 16 | Folded 16-bit value |

## Verification
A wrong position constant changes the result only for words whose byte at that position is nonzero. It shows one cycle after such a word is accepted, so the bench drives words with a single one-hot byte at each position as well as dense words. An error in the XOR tree or in the multiplier array breaks the match between the reduced output and a bit-serial CRC on the first affected word. A wrong enable or valid register shows as a changed value during idle cycles, or as a missing or extra result. The scoreboard catches this within a cycle.

// File: rtl/crcfold_pkg.sv
package crcfold_pkg;

  localparam int BYTE_W = 8;
  localparam int FOLD_W = 2 * BYTE_W;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic validNext;
  } foldCtrl_t;

  // carry-less 8x8 product: AND terms combined with XOR
  function automatic logic [FOLD_W-1:0] clmul8(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [FOLD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ (FOLD_W'(a) << i);
    end
    return acc;
  endfunction

  // x^n mod poly, poly given with its x^8 term
  function automatic logic [BYTE_W-1:0] powMod(input int n, input logic [BYTE_W:0] poly);
    logic [BYTE_W:0] rem;
    rem = 9'd1;
    for (int i = 0; i < 1024; i++) begin
      if (i < n) begin
        rem = rem << 1;
        if (rem[BYTE_W]) rem = rem ^ poly;
      end
    end
    return rem[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/crcfold_ctrl.sv
module crcfold_ctrl
  import crcfold_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output foldCtrl_t ctrl,
  output logic      outValid
);

  always_comb begin
    ctrl.loadEn    = inValid;
    ctrl.validNext = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctrl.validNext;
  end

endmodule

// File: rtl/crcfold_dp.sv
module crcfold_dp
  import crcfold_pkg::*;
#(
  parameter int              NUM_BYTES = 8,
  parameter logic [BYTE_W:0] POLY      = 9'h107,
  localparam int             DATA_W    = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  foldCtrl_t         ctrl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [FOLD_W-1:0] foldOut
);

  logic [FOLD_W-1:0] prodArr [NUM_BYTES];
  logic [FOLD_W-1:0] foldNext;

  // one multiplier per byte lane, constant fixed by lane position
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    localparam logic [BYTE_W-1:0] LANE_K = powMod(BYTE_W * g, POLY);
    assign prodArr[g] = clmul8(dataIn[g*BYTE_W +: BYTE_W], LANE_K);
  end

  always_comb begin
    foldNext = '0;
    for (int i = 0; i < NUM_BYTES; i++) foldNext = foldNext ^ prodArr[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            foldOut <= '0;
    else if (ctrl.loadEn) foldOut <= foldNext;
  end

endmodule

// File: rtl/crcfold_top.sv
module crcfold_top
  import crcfold_pkg::*;
#(
  parameter int              NUM_BYTES = 8,
  parameter logic [BYTE_W:0] POLY      = 9'h107
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [NUM_BYTES*BYTE_W-1:0] dataIn,
  output logic                        outValid,
  output logic [FOLD_W-1:0]           foldOut
);

  foldCtrl_t ctrl;

  crcfold_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  crcfold_dp #(.NUM_BYTES(NUM_BYTES), .POLY(POLY)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .dataIn  (dataIn),
    .foldOut (foldOut)
  );

endmodule

// File: rtl/crcfold_chk.sv
module crcfold_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] dataIn,
  input logic              outValid,
  input logic [15:0]       foldOut
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && foldOut == 16'h0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3
  last_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && dataIn[DATA_W-1:8] == '0) |=> foldOut == {8'h00, $past(dataIn[7:0])});

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(foldOut));

endmodule

bind crcfold_top crcfold_chk #(.DATA_W(NUM_BYTES * 8)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .dataIn   (dataIn),
  .outValid (outValid),
  .foldOut  (foldOut)
);

// File: tb/crcfold_top_tb_top.sv
module crcfold_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [63:0] dataIn;
  logic        outValid;
  logic [15:0] foldOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  crcfold_top dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .dataIn   (dataIn),
    .outValid (outValid),
    .foldOut  (foldOut)
  );

  typedef struct {
    logic [15:0] expV;
    logic [7:0]  expCrc;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // stated position weights, index = byte distance from the end
  localparam logic [7:0] WEIGHT [8] = '{8'h01, 8'h07, 8'h15, 8'h6B,
                                        8'h16, 8'h62, 8'h29, 8'hDF};

  function automatic logic [15:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] r;
    r = 16'h0;
    for (int i = 7; i >= 0; i--) begin
      r = r << 1;
      if (b[i]) r = r ^ {8'h00, a};
    end
    return r;
  endfunction

  function automatic logic [15:0] refFold(input logic [63:0] w);
    logic [15:0] v;
    v = 16'h0;
    for (int k = 0; k < 8; k++) v = v ^ refMul(w[8*k +: 8], WEIGHT[k]);
    return v;
  endfunction

  // bit-serial CRC-8, poly 0x07, zero start, MSB first, no final XOR
  function automatic logic [7:0] serialCrc(input logic [63:0] bits, input int nBits);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = nBits - 1; i >= 0; i--) begin
      fb = c[7] ^ bits[i];
      c  = c << 1;
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendWord(input logic [63:0] w, input string tag);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1;
    dataIn  = w;
    it.expV   = refFold(w);
    it.expCrc = serialCrc(w, 64);
    it.tag    = tag;
    expQ.push_back(it);
  endtask

  task automatic sendFixed(input logic [63:0] w, input logic [15:0] v,
                           input logic [7:0] c, input string tag);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1;
    dataIn  = w;
    it.expV   = v;
    it.expCrc = c;
    it.tag    = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      dataIn  = {$urandom, $urandom};
    end
  endtask

  // monitor: pops the scoreboard, checks hold on idle cycles
  logic [15:0] lastV;
  bit          haveLast = 1'b0;

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected result", 64'(foldOut), 64'h0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(foldOut == it.expV, {"R4 R3 fold value ", it.tag}, 64'(foldOut), 64'(it.expV));
          check(serialCrc({48'h0, foldOut}, 16) == it.expCrc, {"R5 reduced crc ", it.tag},
                64'(serialCrc({48'h0, foldOut}, 16)), 64'(it.expCrc));
        end
        lastV    = foldOut;
        haveLast = 1'b1;
      end else if (haveLast) begin
        check(foldOut == lastV, "R6 hold while idle", 64'(foldOut), 64'(lastV));
      end
    end
  end

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN    = 1'b0;
    inValid = 1'b1;
    dataIn  = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: reset clears even with a valid word present
    check(outValid == 1'b0, "R1 outValid after reset", 64'(outValid), 64'h0);
    check(foldOut == 16'h0, "R1 foldOut after reset", 64'(foldOut), 64'h0);
    inValid = 1'b0;
    rstN    = 1'b1;
    idle(2);

    // R4 R5: stated example, literal expectations
    sendFixed(64'h3132333435363738, 16'h1137, 8'hC7, "example");
    idle(1);
    // R2: result visible exactly one cycle after the strobe
    check(outValid == 1'b1, "R2 valid one cycle later", 64'(outValid), 64'h1);
    idle(1);
    check(outValid == 1'b0, "R2 valid drops after one", 64'(outValid), 64'h0);

    // R3: one-hot byte at each position, first byte 01 gives 00DF
    sendFixed(64'h0100000000000000, 16'h00DF, serialCrc(64'h0100000000000000, 64), "first byte");
    for (int k = 0; k < 8; k++) sendWord(64'hA5 << (8 * k), "one-hot lane");
    sendFixed(64'h00000000000000FF, 16'h00FF, serialCrc(64'hFF, 64), "last byte");
    idle(3);

    // R7: back-to-back stream of dense words
    sendWord(64'hFFFF_FFFF_FFFF_FFFF, "all ones");
    sendWord(64'h0, "all zero");
    sendWord(64'h8000_0000_0000_0001, "edges");
    sendWord(64'hDEAD_BEEF_0123_4567, "mixed");
    for (int i = 0; i < 12; i++) sendWord({$urandom, $urandom}, "stream");
    // R6: idle cycles with changing data must not move the output
    idle(5);

    for (int i = 0; i < 60; i++) begin
      sendWord({$urandom, $urandom}, "gapped");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    // R7: every accepted word produced exactly one result
    check(expQ.size() == 0, "R7 results outstanding", 64'(expQ.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule